// File: doc/BRIEF.md
# Input-Pattern Standby Sequencer

This block decides when a gate driver goes into its low-power standby mode and when it comes back out. No dedicated pin is used. The block watches the two filtered logic command inputs and a free-running time-base strobe, `tick`. The standby pattern is both command inputs high together. Holding that pattern for too long puts the driver to sleep. Waking it takes a timed sequence: first a quiet period on the inputs, then a pattern pulse whose length falls inside a window, then a fixed delay.

The output `standby_o` tells the output stage to hold the gate in its safe, actively-low state. The output `active_o` is its complement. All timing windows are parameters counted in ticks of the time base. Only ticked clock edges advance any timer.

The states are:
- `S_RUN`: active.
- `S_QUIET`: asleep, waiting for a long enough non-pattern period.
- `S_ARMED`: asleep, quiet period met, waiting for a pulse.
- `S_PULSE`: asleep, measuring a pattern pulse.
- `S_WAKE`: asleep, counting the wake-up delay.

The transitions are:
- `S_RUN` to `S_QUIET` when the pattern has been held too long (sleep entry).
- `S_QUIET` to `S_ARMED` when the quiet period is met (quiet met).
- `S_ARMED` to `S_PULSE` when the pattern appears (pulse start).
- `S_PULSE` to `S_WAKE` when the pulse ends inside the window (pulse accepted).
- `S_PULSE` to `S_QUIET` when the pulse ends too early or is held too long (pulse rejected).
- `S_WAKE` to `S_RUN` when the delay ends (wake done).

Top module: `stby_pattern_seq`

## Requirements
- R1: After reset the block is active: `active_o`=1 and `standby_o`=0.
- R2: The standby pattern is `ctl_pos`=1 and `ctl_neg`=1 at the same time. Standby is entered on the clock edge at which the pattern has been sampled on more than STBY_CYC consecutive ticked edges. A run of exactly STBY_CYC ticked edges leaves the block active.
- R3: `standby_o` and `active_o` are registered and are always complements of each other.
- R4: The pattern timer and the wake-delay timer advance only on edges where `tick`=1. With `tick`=0 the outputs do not change, however long the inputs are held.
- R5: While in standby, input changes whose non-pattern runs last no more than FILT_CYC ticks leave `standby_o`=1.
- R6: A wake pulse counts only after a non-pattern run of more than FILT_CYC ticks. Any of the combinations 00, 10 and 01 counts toward that run. A pulse that follows a shorter quiet run is ignored.
- R7: Take a pattern pulse of L ticked edges that follows a valid quiet run. It is accepted if and only if WAKE_CYC < L < STBY_CYC. A pulse still held after STBY_CYC+1 ticks is rejected at once.
- R8: Count from the edge at which an accepted pulse is first sampled low. `active_o` rises on the DLY_CYC-th ticked edge after that edge. Input values during the delay have no effect.
- R9: After a rejected pulse the block waits for a new quiet run of more than FILT_CYC ticks. The sampled-low edge ending the pulse counts as the first tick of that run. A following valid pulse then wakes the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base strobe; timers advance on edges where it is 1 |
| ctl_pos | input | 1 | Filtered non-inverting command input |
| ctl_neg | input | 1 | Filtered inverting command input |
| standby_o | output | 1 | 1 while in standby (gate held in safe, low state) |
| active_o | output | 1 | 1 while in normal operation |

## Verification
The bench builds the block with STBY_CYC=12, WAKE_CYC=4, FILT_CYC=3 and DLY_CYC=6. These short windows make it cheap to sweep every sleep-entry length from 1 to 14 ticks. They also allow every wake-pulse length from 1 to 15 ticks to be tried, so both edges of the acceptance window and the too-long abort are covered. Every rejected pulse is followed by a retry. Further runs gate the time base off during sleep entry and during the wake delay, and cut the quiet period one tick short.

// File: rtl/stby_seq_pkg.sv
package stby_seq_pkg;

    typedef enum logic [2:0] {
        S_RUN   = 3'd0,
        S_QUIET = 3'd1,
        S_ARMED = 3'd2,
        S_PULSE = 3'd3,
        S_WAKE  = 3'd4
    } seq_state_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/stby_run_timer.sv
// Measures how long the standby pattern (or its absence) has lasted, in ticks.
module stby_run_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          pat,
    output logic [CW-1:0] len_now,
    output logic [CW-1:0] prev_len
);
    localparam logic [CW-1:0] SAT = '1;

    logic          pat_q;
    logic [CW-1:0] cnt_q;
    logic          changed;

    assign changed  = pat ^ pat_q;
    assign prev_len = cnt_q;

    // Length of the current run, including this edge's tick.
    always_comb begin
        if (changed)
            len_now = CW'(tick);
        else if (cnt_q == SAT)
            len_now = SAT;
        else
            len_now = cnt_q + CW'(tick);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pat_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            pat_q <= pat;
            cnt_q <= len_now;
        end
    end
endmodule

// File: rtl/stby_wake_delay.sv
// Counts the fixed wake-up delay, regardless of the command inputs.
module stby_wake_delay #(
    parameter int DLY_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    output logic done
);
    localparam int            DW   = (DLY_CYC > 1) ? $clog2(DLY_CYC) : 1;
    localparam logic [DW-1:0] LAST = DW'(DLY_CYC - 1);

    logic [DW-1:0] cnt_q;

    assign done = run && tick && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else if (tick && cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/stby_seq_fsm.sv
module stby_seq_fsm
    import stby_seq_pkg::*;
#(
    parameter int STBY_CYC = 12,
    parameter int WAKE_CYC = 4,
    parameter int FILT_CYC = 3,
    parameter int CW       = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          pat,
    input  logic [CW-1:0] len_now,
    input  logic [CW-1:0] prev_len,
    input  logic          dly_done,
    output logic          dly_run,
    output logic          standby_o,
    output logic          active_o
);
    localparam logic [CW-1:0] STBY_L = CW'(STBY_CYC);
    localparam logic [CW-1:0] WAKE_L = CW'(WAKE_CYC);
    localparam logic [CW-1:0] FILT_L = CW'(FILT_CYC);

    seq_state_t st_q, st_nxt;

    assign dly_run = (st_q == S_WAKE);

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            S_RUN: begin
                // sleep entry
                if (pat && len_now > STBY_L)
                    st_nxt = S_QUIET;
            end
            S_QUIET: begin
                // quiet met
                if (!pat && len_now > FILT_L)
                    st_nxt = S_ARMED;
            end
            S_ARMED: begin
                // pulse start
                if (pat)
                    st_nxt = S_PULSE;
            end
            S_PULSE: begin
                if (pat) begin
                    // pulse rejected: held too long
                    if (len_now > STBY_L)
                        st_nxt = S_QUIET;
                end else if (prev_len > WAKE_L && prev_len < STBY_L) begin
                    // pulse accepted
                    st_nxt = S_WAKE;
                end else begin
                    // pulse rejected: too short or too long
                    st_nxt = S_QUIET;
                end
            end
            S_WAKE: begin
                // wake done
                if (dly_done)
                    st_nxt = S_RUN;
            end
            default: st_nxt = S_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= S_RUN;
        else
            st_q <= st_nxt;
    end

    // Output register, aligned with the state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            standby_o <= 1'b0;
            active_o  <= 1'b1;
        end else begin
            standby_o <= (st_nxt != S_RUN);
            active_o  <= (st_nxt == S_RUN);
        end
    end

    // The time base is used by the sub-timers; it is kept here for the interface.
    logic unused_tick;
    assign unused_tick = tick;
endmodule

// File: rtl/stby_pattern_seq.sv
module stby_pattern_seq
    import stby_seq_pkg::*;
#(
    parameter int STBY_CYC = 28000,
    parameter int WAKE_CYC = 2000,
    parameter int FILT_CYC = 28,
    parameter int DLY_CYC  = 14000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic ctl_pos,
    input  logic ctl_neg,
    output logic standby_o,
    output logic active_o
);
    localparam int LIM = max2(STBY_CYC, FILT_CYC) + 1;
    localparam int CW  = $clog2(LIM + 1);

    logic          pat;
    logic [CW-1:0] len_now;
    logic [CW-1:0] prev_len;
    logic          dly_run;
    logic          dly_done;

    assign pat = ctl_pos & ctl_neg;

    stby_run_timer #(.CW(CW)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .pat      (pat),
        .len_now  (len_now),
        .prev_len (prev_len)
    );

    stby_wake_delay #(.DLY_CYC(DLY_CYC)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .run   (dly_run),
        .done  (dly_done)
    );

    stby_seq_fsm #(
        .STBY_CYC (STBY_CYC),
        .WAKE_CYC (WAKE_CYC),
        .FILT_CYC (FILT_CYC),
        .CW       (CW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .pat       (pat),
        .len_now   (len_now),
        .prev_len  (prev_len),
        .dly_done  (dly_done),
        .dly_run   (dly_run),
        .standby_o (standby_o),
        .active_o  (active_o)
    );
endmodule

// File: rtl/stby_pattern_seq_chk.sv
module stby_pattern_seq_chk #(
    parameter int DLY_CYC = 14000
) (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic ctl_pos,
    input logic ctl_neg,
    input logic standby_o,
    input logic active_o
);
    localparam int            SW  = $clog2(DLY_CYC + 2);
    localparam logic [SW-1:0] SAT = SW'(DLY_CYC + 1);
    localparam logic [SW-1:0] MIN = SW'(DLY_CYC);

    logic [SW-1:0] sb_ticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sb_ticks <= '0;
        else if (!standby_o)
            sb_ticks <= '0;
        else if (tick && sb_ticks != SAT)
            sb_ticks <= sb_ticks + 1'b1;
    end

    // R3
    outputs_complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby_o != active_o);

    // R2
    entry_needs_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(standby_o) |-> $past(ctl_pos && ctl_neg));

    // R4
    frozen_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !tick) |=> active_o);

    // R4
    wake_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(standby_o) |-> $past(tick));

    // R8
    wake_delay_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(standby_o) |-> (sb_ticks >= MIN));
endmodule

bind stby_pattern_seq stby_pattern_seq_chk #(.DLY_CYC(DLY_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .ctl_pos   (ctl_pos),
    .ctl_neg   (ctl_neg),
    .standby_o (standby_o),
    .active_o  (active_o)
);

// File: tb/stby_pattern_seq_tb.sv
module stby_pattern_seq_tb;
    localparam int STBY = 12;
    localparam int WAKE = 4;
    localparam int FILT = 3;
    localparam int DLY  = 6;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic tick  = 1'b1;
    logic cp    = 1'b0;
    logic cn    = 1'b0;
    logic standby_o;
    logic active_o;

    int  n_chk    = 0;
    int  n_bad    = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    stby_pattern_seq #(
        .STBY_CYC (STBY),
        .WAKE_CYC (WAKE),
        .FILT_CYC (FILT),
        .DLY_CYC  (DLY)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .ctl_pos   (cp),
        .ctl_neg   (cn),
        .standby_o (standby_o),
        .active_o  (active_o)
    );

    // Apply (p,n) for k clock edges; returns at a falling edge.
    task automatic drive(input logic p, input logic n, input int k);
        repeat (k) begin
            cp = p;
            cn = n;
            @(negedge clk);
        end
    endtask

    task automatic expect_sb(input string req, input logic exp_sb);
        n_chk++;
        if (standby_o !== exp_sb || active_o !== !exp_sb) begin
            n_bad++;
            $display("FAIL %s: standby=%b active=%b, expected standby=%b active=%b",
                     req, standby_o, active_o, exp_sb, !exp_sb);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cp    = 1'b0;
        cn    = 1'b0;
        tick  = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic enter_sb();
        drive(1'b1, 1'b1, STBY + 1);
    endtask

    // Pulse end: the first low edge, then DLY edges in total.
    task automatic finish_pulse(input logic exp_wake, input string req);
        drive(1'b0, 1'b0, DLY);
        expect_sb(req, 1'b1);
        drive(1'b0, 1'b0, 1);
        expect_sb(req, !exp_wake);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        expect_sb("R1 reset", 1'b0);

        // R2 R3: sweep the sleep-entry hold length
        for (int n = 1; n <= STBY + 2; n++) begin
            do_reset();
            drive(1'b1, 1'b1, n);
            expect_sb("R2 R3 entry length", (n > STBY));
        end

        // R4: no ticks, no entry
        do_reset();
        tick = 1'b0;
        drive(1'b1, 1'b1, 3 * STBY);
        expect_sb("R4 entry frozen without tick", 1'b0);
        tick = 1'b1;
        drive(1'b1, 1'b1, STBY);
        expect_sb("R4 entry after ticks resume, one short", 1'b0);
        drive(1'b1, 1'b1, 1);
        expect_sb("R4 entry after ticks resume", 1'b1);

        // R5: input changes while asleep, quiet runs too short
        do_reset();
        enter_sb();
        for (int i = 0; i < 24; i++) begin
            case (i % 3)
                0:       drive(1'b1, 1'b0, 1);
                1:       drive(1'b1, 1'b1, 1);
                default: drive(1'b0, 1'b1, 1);
            endcase
            expect_sb("R5 stays asleep", 1'b1);
        end

        // R6: quiet run one tick short, so the pulse is ignored
        do_reset();
        enter_sb();
        drive(1'b0, 1'b0, FILT);
        drive(1'b1, 1'b1, WAKE + 1);
        finish_pulse(1'b0, "R6 short quiet run");
        drive(1'b1, 1'b1, WAKE + 1);
        finish_pulse(1'b1, "R6 valid after long quiet run");

        // R6: mixed non-pattern combinations count as quiet
        do_reset();
        enter_sb();
        drive(1'b1, 1'b0, 1);
        drive(1'b0, 1'b1, 1);
        drive(1'b0, 1'b0, 1);
        drive(1'b1, 1'b0, 1);
        drive(1'b1, 1'b1, WAKE + 1);
        finish_pulse(1'b1, "R6 mixed quiet combinations");

        // R7 R9: sweep the wake-pulse length, retrying after every rejection
        for (int L = 1; L <= STBY + 3; L++) begin
            logic ok;
            ok = (L > WAKE) && (L < STBY);
            do_reset();
            enter_sb();
            drive(1'b0, 1'b0, FILT + 1);
            drive(1'b1, 1'b1, L);
            finish_pulse(ok, "R7 pulse window");
            if (!ok) begin
                drive(1'b1, 1'b1, WAKE + 1);
                finish_pulse(1'b1, "R9 retry after rejected pulse");
            end
        end

        // R8: the pattern applied during the delay has no effect
        do_reset();
        enter_sb();
        drive(1'b0, 1'b0, FILT + 1);
        drive(1'b1, 1'b1, WAKE + 1);
        drive(1'b0, 1'b0, 1);
        drive(1'b1, 1'b1, DLY - 1);
        expect_sb("R8 still in delay", 1'b1);
        drive(1'b1, 1'b1, 1);
        expect_sb("R8 wake despite inputs", 1'b0);
        drive(1'b0, 1'b0, 1);
        expect_sb("R8 stays active", 1'b0);

        // R4: the delay counts ticks only
        do_reset();
        enter_sb();
        drive(1'b0, 1'b0, FILT + 1);
        drive(1'b1, 1'b1, WAKE + 1);
        drive(1'b0, 1'b0, 1);
        tick = 1'b0;
        drive(1'b0, 1'b0, 20);
        expect_sb("R4 delay frozen without tick", 1'b1);
        tick = 1'b1;
        drive(1'b0, 1'b0, DLY - 1);
        expect_sb("R4 delay one tick short", 1'b1);
        drive(1'b0, 1'b0, 1);
        expect_sb("R4 delay complete", 1'b0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule